// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block picks, for each source operand of the instruction in the execute stage of a five-stage in-order pipeline, where that operand's value comes from. There are three candidates: the value read from the register file during decode, the result sitting in the execute/memory pipeline register, or the value being written back in this cycle. Selection compares the operand's source index against the destination index and write-enable of the two older in-flight instructions. The younger instruction always wins. Register zero is never a forwarding source.

A second path handles a write and a read of the same register in one cycle. When a decode-stage read names the register the writeback stage is writing, the read returns the incoming value instead of the stale stored one. This is an explicit multiplexer, so every register in the design updates on the same rising clock edge.

A thin wrapper holds the forwarding logic, a register file and the two execute operand multiplexers. The pipeline registers, the ALU and instruction decode stay outside. The execute-stage register values, the memory-stage result and the writeback write port are all driven from outside the block.

Top module: `fwd_datapath`

## Requirements
- R1: An execute operand selects the execute/memory result (select code 2'b10) when the memory stage's write-enable is high, its destination is nonzero, and the destination equals that operand's source index.
- R2: When R1 does not apply, an execute operand selects the writeback value (select code 2'b01) when the writeback write-enable is high, its destination is nonzero, and the destination equals the operand's source index.
- R3: When both stages hold the operand's nonzero source index with write-enable set, the execute/memory result is chosen.
- R4: An execute operand whose source index is 0 always selects the register-file value (select code 2'b00), whatever the stage destinations are.
- R5: Operands A and B are resolved independently under identical rules. A match on one operand never changes the other operand's select.
- R6: A decode read whose index equals a nonzero writeback destination, while writeback write-enable is high, returns the writeback data in the same cycle.
- R7: Register 0 reads as zero on both decode ports, including right after an instruction targeting register 0 has been written back.
- R8: Each execute operand output equals the source named by its select code: 2'b00 the register-file value input, 2'b10 the memory-stage data, 2'b01 the writeback data. Code 2'b11 never appears.
- R9: After reset, every register reads as zero on both decode ports.
- R10: A writeback to a nonzero register is stored on the rising clock edge. A program of dependent adds run through a bench-modelled pipeline produces the same results as sequential execution, for dependence distances 1 to 4 and for two back-to-back writes to one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the register file |
| id_rs_a_i | input | 5 | Decode-stage source index, operand A |
| id_rs_b_i | input | 5 | Decode-stage source index, operand B |
| id_data_a_o | output | 32 | Decode read data A, with writeback bypass |
| id_data_b_o | output | 32 | Decode read data B, with writeback bypass |
| ex_rs_a_i | input | 5 | Execute-stage source index, operand A |
| ex_rs_b_i | input | 5 | Execute-stage source index, operand B |
| ex_rf_a_i | input | 32 | Register value latched at decode for operand A |
| ex_rf_b_i | input | 32 | Register value latched at decode for operand B |
| ex_sel_a_o | output | 2 | Forward select for operand A |
| ex_sel_b_o | output | 2 | Forward select for operand B |
| ex_op_a_o | output | 32 | Resolved execute operand A |
| ex_op_b_o | output | 32 | Resolved execute operand B |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | 5 | Memory-stage destination index |
| mem_data_i | input | 32 | Memory-stage result |
| wb_we_i | input | 1 | Writeback write-enable |
| wb_rd_i | input | 5 | Writeback destination index |
| wb_data_i | input | 32 | Writeback data |

## Verification
The hardest case to reach from the ports is the one where all sources contend at once. That case has a double write still in flight, with the older copy in writeback and the younger in memory, while decode reads the same register in the same cycle. The stimulus reaches it in two ways. The first is an exhaustive sweep over a four-register window, covering every combination of both write-enables, both destinations and both source indices. The second runs a short dependent-add program through a pipeline modelled in the bench, where back-to-back writes to one register and writes to register zero put those overlaps in specific cycles.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_i,
  input  logic             mem_we_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             wb_we_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  output logic [1:0]       sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  // younger stage first
  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int IDX_W = 5,
  parameter int NOPS  = 2
) (
  input  logic [NOPS-1:0][IDX_W-1:0] ex_src_i,
  input  logic [NOPS-1:0][IDX_W-1:0] id_src_i,
  input  logic                       mem_we_i,
  input  logic [IDX_W-1:0]           mem_rd_i,
  input  logic                       wb_we_i,
  input  logic [IDX_W-1:0]           wb_rd_i,
  output logic [NOPS-1:0][1:0]       ex_sel_o,
  output logic [NOPS-1:0]            id_byp_o
);
  logic wb_live;
  assign wb_live = wb_we_i && (wb_rd_i != '0);

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_pick #(.IDX_W(IDX_W)) u_pick (
      .src_i    (ex_src_i[g]),
      .mem_we_i (mem_we_i),
      .mem_rd_i (mem_rd_i),
      .wb_we_i  (wb_we_i),
      .wb_rd_i  (wb_rd_i),
      .sel_o    (ex_sel_o[g])
    );
    assign id_byp_o[g] = wb_live && (id_src_i[g] == wb_rd_i);
  end
endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32,
  parameter int NRD    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NRD-1:0][IDX_W-1:0]   raddr_i,
  input  logic [NRD-1:0]              byp_i,
  output logic [NRD-1:0][DATA_W-1:0]  rdata_o
);
  localparam int NREG = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (byp_i[g])                rdata_o[g] = wdata_i;
      else if (raddr_i[g] == '0)   rdata_o[g] = '0;
      else                         rdata_o[g] = mem_q[raddr_i[g]];
    end
  end

  p_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (waddr_i != '0)) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  p_reg0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (waddr_i == '0)) |=> (mem_q[0] == '0));
endmodule

// File: rtl/fwd_op_mux.sv
module fwd_op_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] wb_i,
  output logic [DATA_W-1:0] op_o
);
  always_comb begin
    case (sel_i)
      SEL_MEM: op_o = mem_i;
      SEL_WB:  op_o = wb_i;
      default: op_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  id_rs_a_i,
  input  logic [IDX_W-1:0]  id_rs_b_i,
  output logic [DATA_W-1:0] id_data_a_o,
  output logic [DATA_W-1:0] id_data_b_o,
  input  logic [IDX_W-1:0]  ex_rs_a_i,
  input  logic [IDX_W-1:0]  ex_rs_b_i,
  input  logic [DATA_W-1:0] ex_rf_a_i,
  input  logic [DATA_W-1:0] ex_rf_b_i,
  output logic [1:0]        ex_sel_a_o,
  output logic [1:0]        ex_sel_b_o,
  output logic [DATA_W-1:0] ex_op_a_o,
  output logic [DATA_W-1:0] ex_op_b_o,
  input  logic              mem_we_i,
  input  logic [IDX_W-1:0]  mem_rd_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              wb_we_i,
  input  logic [IDX_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][IDX_W-1:0]  ex_src, id_src;
  logic [NOPS-1:0][1:0]        ex_sel;
  logic [NOPS-1:0]             id_byp;
  logic [NOPS-1:0][DATA_W-1:0] ex_rf, ex_op, id_data;

  assign ex_src = {ex_rs_b_i, ex_rs_a_i};
  assign id_src = {id_rs_b_i, id_rs_a_i};
  assign ex_rf  = {ex_rf_b_i, ex_rf_a_i};

  fwd_unit #(.IDX_W(IDX_W), .NOPS(NOPS)) u_unit (
    .ex_src_i (ex_src),
    .id_src_i (id_src),
    .mem_we_i (mem_we_i),
    .mem_rd_i (mem_rd_i),
    .wb_we_i  (wb_we_i),
    .wb_rd_i  (wb_rd_i),
    .ex_sel_o (ex_sel),
    .id_byp_o (id_byp)
  );

  fwd_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NRD(NOPS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we_i),
    .waddr_i (wb_rd_i),
    .wdata_i (wb_data_i),
    .raddr_i (id_src),
    .byp_i   (id_byp),
    .rdata_o (id_data)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_mux
    fwd_op_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i (ex_sel[g]),
      .rf_i  (ex_rf[g]),
      .mem_i (mem_data_i),
      .wb_i  (wb_data_i),
      .op_o  (ex_op[g])
    );
  end

  assign ex_sel_a_o  = ex_sel[0];
  assign ex_sel_b_o  = ex_sel[1];
  assign ex_op_a_o   = ex_op[0];
  assign ex_op_b_o   = ex_op[1];
  assign id_data_a_o = id_data[0];
  assign id_data_b_o = id_data[1];

  p_mem_fwd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && (mem_rd_i != '0) && (mem_rd_i == ex_rs_a_i)) |-> (ex_op_a_o == mem_data_i));

  p_wb_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && (wb_rd_i != '0) && (wb_rd_i == ex_rs_a_i) &&
     !(mem_we_i && (mem_rd_i == ex_rs_a_i))) |-> (ex_op_a_o == wb_data_i));

  p_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && wb_we_i && (ex_rs_a_i != '0) && (mem_rd_i == ex_rs_a_i) &&
     (wb_rd_i == ex_rs_a_i)) |-> (ex_sel_a_o == SEL_MEM));

  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs_a_i == '0) |-> ((ex_sel_a_o == SEL_RF) && (ex_op_a_o == ex_rf_a_i)));

  p_mem_fwd_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && (mem_rd_i != '0) && (mem_rd_i == ex_rs_b_i)) |-> (ex_op_b_o == mem_data_i));

  p_dec_byp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && (wb_rd_i != '0) && (id_rs_b_i == wb_rd_i)) |-> (id_data_b_o == wb_data_i));

  p_rd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs_a_i == '0) |-> (id_data_a_o == '0));

  p_sel_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_sel_a_o != 2'b11) && (ex_sel_b_o != 2'b11));
endmodule

// File: tb/sim_fwd_datapath.sv
`timescale 1ns/1ps
module sim_fwd_datapath;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  id_rs_a_i = '0, id_rs_b_i = '0, ex_rs_a_i = '0, ex_rs_b_i = '0;
  logic [31:0] ex_rf_a_i = '0, ex_rf_b_i = '0;
  logic        mem_we_i = 1'b0, wb_we_i = 1'b0;
  logic [4:0]  mem_rd_i = '0, wb_rd_i = '0;
  logic [31:0] mem_data_i = '0, wb_data_i = '0;
  logic [31:0] id_data_a_o, id_data_b_o, ex_op_a_o, ex_op_b_o;
  logic [1:0]  ex_sel_a_o, ex_sel_b_o;

  always #2.5 clk_i = ~clk_i;

  fwd_datapath u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [32];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected select from the requirements
  function automatic logic [1:0] exp_sel(input logic [4:0] rs, input logic mwe, input logic [4:0] mrd,
                                         input logic wwe, input logic [4:0] wrd);
    if (mwe && mrd != 0 && mrd == rs) return 2'b10;
    if (wwe && wrd != 0 && wrd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_id(input logic [4:0] rs);
    if (wb_we_i && wb_rd_i != 0 && rs == wb_rd_i) return wb_data_i;
    return model[rs];
  endfunction

  typedef struct {
    bit v; logic [4:0] d, sa, sb; logic [31:0] imm, exp, la, lb, res;
  } stage_t;

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  always @(posedge clk_i)
    if (rst_ni && wb_we_i && wb_rd_i != 0) model[wb_rd_i] <= wb_data_i;

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 / R7: reset state
    for (int r = 0; r < 32; r++) begin
      id_rs_a_i = r[4:0]; id_rs_b_i = 5'(31 - r);
      #1;
      chk(id_data_a_o == 0, "R9 reset read A", id_data_a_o, 0);
      chk(id_data_b_o == 0, "R9 reset read B", id_data_b_o, 0);
    end

    // exhaustive sweep over regs 0..3
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk_i);
      mem_we_i   = c[0];
      wb_we_i    = c[1];
      mem_rd_i   = 5'(c[3:2]);
      wb_rd_i    = 5'(c[5:4]);
      ex_rs_a_i  = 5'(c[7:6]);
      ex_rs_b_i  = 5'(c[9:8]);
      id_rs_a_i  = ex_rs_b_i;
      id_rs_b_i  = ex_rs_a_i;
      ex_rf_a_i  = 32'h1000_0000 + c;
      ex_rf_b_i  = 32'h2000_0000 + c;
      mem_data_i = 32'hA000_0000 + c;
      wb_data_i  = 32'h5000_0000 + c;
      #1;
      begin
        logic [1:0] ea, eb;
        logic [31:0] oa, ob;
        ea = exp_sel(ex_rs_a_i, mem_we_i, mem_rd_i, wb_we_i, wb_rd_i);
        eb = exp_sel(ex_rs_b_i, mem_we_i, mem_rd_i, wb_we_i, wb_rd_i);
        oa = (ea == 2'b10) ? mem_data_i : (ea == 2'b01) ? wb_data_i : ex_rf_a_i;
        ob = (eb == 2'b10) ? mem_data_i : (eb == 2'b01) ? wb_data_i : ex_rf_b_i;
        // R1 R2 R3 R4 cover select A; R5 operand B
        chk(ex_sel_a_o == ea, "R1/R2/R3/R4 sel A", 32'(ex_sel_a_o), 32'(ea));
        chk(ex_sel_b_o == eb, "R5 sel B", 32'(ex_sel_b_o), 32'(eb));
        chk(ex_op_a_o == oa, "R8 operand A", ex_op_a_o, oa);
        chk(ex_op_b_o == ob, "R8 operand B", ex_op_b_o, ob);
        chk(id_data_a_o == exp_id(id_rs_a_i), "R6 decode A", id_data_a_o, exp_id(id_rs_a_i));
        chk(id_data_b_o == exp_id(id_rs_b_i), "R6/R7 decode B", id_data_b_o, exp_id(id_rs_b_i));
      end
    end

    // R10: dependent-add program through a bench pipeline
    begin
      stage_t prog [16];
      stage_t s_id, s_ex, s_mem, s_wb, bub;
      logic [31:0] arch [32];
      int pc;
      logic [4:0] pd [16], pa [16], pb [16];
      logic [31:0] pi [16];
      pd = '{1,2,3,4,5,5,6,0,7,8,0,9,10,10,11,12};
      pa = '{0,1,1,1,3,5,5,6,0,7,8,0,9,10,10,0};
      pb = '{0,1,0,2,4,1,5,6,0,0,8,8,9,10,10,11};
      pi = '{5,1,2,0,7,1,0,9,3,0,1,0,4,6,2,8};
      for (int i = 0; i < 32; i++) arch[i] = model[i];
      for (int i = 0; i < 16; i++) begin
        prog[i] = '{v:1, d:pd[i], sa:pa[i], sb:pb[i], imm:pi[i], exp:0, la:0, lb:0, res:0};
        prog[i].exp = arch[pa[i]] + arch[pb[i]] + pi[i];
        if (pd[i] != 0) arch[pd[i]] = prog[i].exp;
      end
      bub = '{v:0, d:0, sa:0, sb:0, imm:0, exp:0, la:0, lb:0, res:0};
      s_ex = bub; s_mem = bub; s_wb = bub;
      s_id = prog[0]; pc = 1;
      for (int cyc = 0; cyc < 22; cyc++) begin
        @(negedge clk_i);
        id_rs_a_i = s_id.sa;  id_rs_b_i = s_id.sb;
        ex_rs_a_i = s_ex.sa;  ex_rs_b_i = s_ex.sb;
        ex_rf_a_i = s_ex.la;  ex_rf_b_i = s_ex.lb;
        mem_we_i  = s_mem.v;  mem_rd_i = s_mem.d; mem_data_i = s_mem.res;
        wb_we_i   = s_wb.v;   wb_rd_i  = s_wb.d;  wb_data_i  = s_wb.res;
        #1;
        if (s_ex.v) begin
          s_ex.res = ex_op_a_o + ex_op_b_o + s_ex.imm;
          chk(s_ex.res == s_ex.exp, "R10 program result", s_ex.res, s_ex.exp);
        end
        s_id.la = id_data_a_o; s_id.lb = id_data_b_o;
        @(posedge clk_i);
        s_wb = s_mem; s_mem = s_ex; s_ex = s_id;
        if (pc < 16) begin s_id = prog[pc]; pc++; end
        else s_id = bub;
      end
      @(negedge clk_i);
      mem_we_i = 0; wb_we_i = 0;
      for (int r = 0; r < 16; r++) begin
        id_rs_a_i = r[4:0]; id_rs_b_i = r[4:0];
        #1;
        chk(id_data_a_o == arch[r], "R10/R7 final register", id_data_a_o, arch[r]);
      end
    end
    finish_run();
  end
endmodule